// File: doc/BRIEF.md
# Lazy Self-Invalidating Private Cache Controller

This controller sits between one core and a shared cache level. It holds a small direct-mapped array of one-word lines, and each line is Invalid, Shared or Private. Coherence is kept lazily. No invalidation ever arrives from other caches and none is sent out. A Shared copy instead ages out after a fixed number of local read hits and is then fetched again. On a read miss, the controller drops its Shared copies in bulk. This guarantees that later reads observe data at least as recent as the value the miss brought in.

Every fill from the shared level carries three things: the data word, a grant that says whether the line is now held privately, and the timestamp of the write that produced the data. A register keeps the largest timestamp seen so far. If an incoming fill's timestamp is not above that register, the write is already ordered before something this core has observed, so the bulk drop is skipped. Writes are written through to the shared level one at a time, in program order, and do not allocate lines. A write that hits a cached line also updates the local copy.

Top module: `lazy_l1_ctrl`

## Requirements
- R1: After reset, every line is Invalid, the last-seen timestamp is zero, `core_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: A read that misses sends one downstream read (`mem_req_we`=0) for the same address. `rsp_valid` pulses one cycle after the fill response, with `rsp_rdata` equal to the fill data.
- R3: A read that hits a valid line is answered one cycle after acceptance, with no downstream request.
- R4: After a fill in Shared state (`mem_rsp_excl`=0), the line serves exactly HIT_LIMIT local read hits. The next read to it is treated as a miss and re-fetches. The fill resets the line's hit counter to zero.
- R5: A line filled in Private state (`mem_rsp_excl`=1) never ages out and survives bulk invalidation.
- R6: When a read fill arrives with `mem_rsp_ts` strictly greater than the last-seen timestamp, every Shared line other than the one being filled becomes Invalid in that same cycle.
- R7: When a read fill arrives with `mem_rsp_ts` less than or equal to the last-seen timestamp, the other Shared lines stay valid.
- R8: Every write is sent downstream (`mem_req_we`=1) with its address and data. Writes leave one at a time and in program order. A write never raises `rsp_valid` and does not allocate a line.
- R9: A write whose address matches a cached line updates that line's data and leaves its state unchanged.
- R10: While a miss or a write is outstanding, `core_ready` is 0. `mem_req_valid`, `mem_req_addr` and `mem_req_we` hold steady until `mem_req_ready` is seen.
- R11: The last-seen timestamp is the maximum of all read-fill timestamps accepted since reset, and it never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_valid | input | 1 | Core request present |
| core_ready | output | 1 | Controller can take a core request |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Word address |
| core_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data pulse |
| rsp_rdata | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Downstream request present |
| mem_req_ready | input | 1 | Shared level takes the request |
| mem_req_we | output | 1 | Downstream request is a write |
| mem_req_addr | output | ADDR_W | Downstream address |
| mem_req_wdata | output | DATA_W | Downstream write data |
| mem_rsp_valid | input | 1 | Fill or write acknowledge |
| mem_rsp_data | input | DATA_W | Fill data |
| mem_rsp_excl | input | 1 | Fill grants Private ownership |
| mem_rsp_ts | input | TS_W | Timestamp of the write that produced the fill data |

## Verification
Reads are issued in runs to one address, so the hit count at which a Shared line expires can be observed directly, and runs to a Private line confirm that such a line never expires. Fills are given rising, equal and falling timestamps, and other cached lines are probed after each fill. This separates a fill that drops Shared copies from one that skips the drop, and it exposes a register that keeps only the latest timestamp instead of the largest. Write sequences to cached and uncached addresses show local updates, no allocation, and the order in which writes reach the shared level.

// File: rtl/lazy_l1_ctrl.sv
module lazy_l1_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 2,
  parameter int TS_W      = 8,
  parameter int HIT_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_valid,
  output logic              core_ready,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_excl,
  input  logic [TS_W-1:0]   mem_rsp_ts
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int CNT_W = $clog2(HIT_LIMIT + 1);
  localparam logic [1:0] L_INV = 2'd0;
  localparam logic [1:0] L_SHR = 2'd1;
  localparam logic [1:0] L_PRV = 2'd2;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fsm_t;
  fsm_t st;

  logic [1:0]        lst  [LINES];
  logic [TAG_W-1:0]  ltag [LINES];
  logic [DATA_W-1:0] ldat [LINES];
  logic [CNT_W-1:0]  lcnt [LINES];

  logic [ADDR_W-1:0] p_addr;
  logic              p_we;
  logic [DATA_W-1:0] p_wdata;
  logic [TS_W-1:0]   last_ts_q;

  logic [IDX_W-1:0] c_idx, f_idx;
  logic [TAG_W-1:0] c_tag;
  logic tag_eq, fresh, rd_hit, accept, skip_inv;

  assign c_idx    = core_addr[IDX_W-1:0];
  assign c_tag    = core_addr[ADDR_W-1:IDX_W];
  assign f_idx    = p_addr[IDX_W-1:0];
  assign tag_eq   = (lst[c_idx] != L_INV) && (ltag[c_idx] == c_tag);
  assign fresh    = (lst[c_idx] == L_PRV) || (lcnt[c_idx] < CNT_W'(HIT_LIMIT));
  assign rd_hit   = tag_eq && fresh;
  assign accept   = core_valid && core_ready;
  assign skip_inv = (mem_rsp_ts <= last_ts_q);

  assign core_ready    = (st == F_IDLE);
  assign mem_req_valid = (st == F_REQ);
  assign mem_req_we    = p_we;
  assign mem_req_addr  = p_addr;
  assign mem_req_wdata = p_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= F_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      p_addr    <= '0;
      p_we      <= 1'b0;
      p_wdata   <= '0;
      last_ts_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        lst[i]  <= L_INV;
        ltag[i] <= '0;
        ldat[i] <= '0;
        lcnt[i] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        F_IDLE: if (accept) begin
          if (core_we) begin
            p_addr  <= core_addr;
            p_we    <= 1'b1;
            p_wdata <= core_wdata;
            st      <= F_REQ;
            if (tag_eq) ldat[c_idx] <= core_wdata;
          end else if (rd_hit) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= ldat[c_idx];
            if (lst[c_idx] == L_SHR && lcnt[c_idx] < CNT_W'(HIT_LIMIT))
              lcnt[c_idx] <= lcnt[c_idx] + CNT_W'(1);
          end else begin
            p_addr <= core_addr;
            p_we   <= 1'b0;
            st     <= F_REQ;
          end
        end
        F_REQ: if (mem_req_ready) st <= F_WAIT;
        F_WAIT: if (mem_rsp_valid) begin
          st <= F_IDLE;
          if (!p_we) begin
            if (!skip_inv) begin
              for (int i = 0; i < LINES; i++)
                if (lst[i] == L_SHR) lst[i] <= L_INV;
              last_ts_q <= mem_rsp_ts;
            end
            lst[f_idx]  <= mem_rsp_excl ? L_PRV : L_SHR;
            ltag[f_idx] <= p_addr[ADDR_W-1:IDX_W];
            ldat[f_idx] <= mem_rsp_data;
            lcnt[f_idx] <= '0;
            rsp_valid   <= 1'b1;
            rsp_rdata   <= mem_rsp_data;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lazy_l1_ctrl_chk.sv
module lazy_l1_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int TS_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              core_valid,
  input logic              core_ready,
  input logic              core_we,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [TS_W-1:0]   last_ts
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (core_ready && !rsp_valid && !mem_req_valid && last_ts == '0));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

  // R10
  busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !core_ready);

  // R8
  write_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (core_valid && core_ready && core_we) |=> !rsp_valid);

  // R11
  ts_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (last_ts >= $past(last_ts)));
endmodule

bind lazy_l1_ctrl lazy_l1_ctrl_chk #(.ADDR_W(ADDR_W), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst(rst), .core_valid(core_valid), .core_ready(core_ready),
  .core_we(core_we), .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .last_ts(last_ts_q)
);

// File: tb/tb_lazy_l1_ctrl.sv
module tb_lazy_l1_ctrl;
  localparam int AW = 8, DW = 32, TW = 8, LIM = 3;

  logic clk = 0, rst = 1;
  logic core_valid = 0, core_we = 0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic core_ready, rsp_valid, mem_req_valid, mem_req_we;
  logic [DW-1:0] rsp_rdata, mem_req_wdata;
  logic [AW-1:0] mem_req_addr;
  logic mem_req_ready = 0, mem_rsp_valid = 0, mem_rsp_excl = 0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic [TW-1:0] mem_rsp_ts = '0;

  lazy_l1_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(2), .TS_W(TW), .HIT_LIMIT(LIM)) dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, nreq = 0;
  logic [DW-1:0] mem [256];
  logic [AW-1:0] log_addr [64];
  logic          log_we   [64];
  logic [DW-1:0] log_data [64];
  logic [TW-1:0] nts = '0;
  logic          nex = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE0000 + i;
    forever begin
      @(negedge clk);
      if (mem_req_valid && !rst) begin
        mem_req_ready = 1;
        log_addr[nreq % 64] = mem_req_addr;
        log_we[nreq % 64]   = mem_req_we;
        log_data[nreq % 64] = mem_req_wdata;
        if (mem_req_we) mem[mem_req_addr] = mem_req_wdata;
        mem_rsp_data = mem[mem_req_addr];
        nreq++;
        @(negedge clk);
        mem_req_ready = 0;
        mem_rsp_valid = 1;
        mem_rsp_ts    = nts;
        mem_rsp_excl  = nex;
        @(negedge clk);
        mem_rsp_valid = 0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  task automatic rd(input logic [AW-1:0] a, input logic [TW-1:0] ts, input logic ex,
                    output logic [DW-1:0] d, output int delta);
    int n0;
    @(negedge clk);
    nts = ts; nex = ex; n0 = nreq;
    core_valid = 1; core_we = 0; core_addr = a;
    while (!core_ready) @(negedge clk);
    @(negedge clk);
    core_valid = 0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
    delta = nreq - n0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] v);
    int n0;
    @(negedge clk);
    n0 = nreq;
    core_valid = 1; core_we = 1; core_addr = a; core_wdata = v;
    while (!core_ready) @(negedge clk);
    @(negedge clk);
    core_valid = 0; core_we = 0;
    chk(!core_ready && !rsp_valid, "R10 stall during write", {31'd0, core_ready}, 0);
    while (!core_ready) @(negedge clk);
    chk(nreq - n0 == 1, "R8 write sent downstream", nreq - n0, 1);
    chk(log_we[n0 % 64] && log_addr[n0 % 64] == a && log_data[n0 % 64] == v,
        "R8 write addr/data", log_data[n0 % 64], v);
  endtask

  task automatic t_reset();
    chk(core_ready === 1'b1, "R1 ready", {31'd0, core_ready}, 1);
    chk(rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R1 outputs idle",
        {30'd0, rsp_valid, mem_req_valid}, 0);
  endtask

  task automatic t_miss_hit_expire();
    logic [DW-1:0] d; int n;
    rd(8'h01, 1, 0, d, n);
    chk(n == 1, "R2 miss goes downstream", n, 1);
    chk(d == mem[8'h01], "R2 fill data", d, mem[8'h01]);
    chk(log_addr[(nreq-1) % 64] == 8'h01 && !log_we[(nreq-1) % 64], "R2 read address",
        log_addr[(nreq-1) % 64], 8'h01);
    for (int k = 0; k < LIM; k++) begin
      rd(8'h01, 1, 0, d, n);
      chk(n == 0 && d == mem[8'h01], "R3 local hit", n, 0);
    end
    rd(8'h01, 1, 0, d, n);
    chk(n == 1, "R4 expired line refetched", n, 1);
    rd(8'h01, 1, 0, d, n);
    chk(n == 0, "R4 counter reset after refetch", n, 0);
  endtask

  task automatic t_private_and_inv();
    logic [DW-1:0] d; int n;
    rd(8'h02, 2, 1, d, n);
    chk(n == 1, "R5 private fill", n, 1);
    for (int k = 0; k < LIM + 2; k++) begin
      rd(8'h02, 0, 0, d, n);
      chk(n == 0, "R5 private never expires", n, 0);
    end
    rd(8'h01, 2, 0, d, n);
    chk(n == 1, "R6 shared line dropped by newer fill", n, 1);
    rd(8'h03, 3, 0, d, n);
    rd(8'h02, 0, 0, d, n);
    chk(n == 0, "R6 private line kept", n, 0);
    rd(8'h01, 3, 0, d, n);
    chk(n == 1, "R6 shared line dropped again", n, 1);
    rd(8'h10, 1, 0, d, n);
    chk(n == 1, "R7 older fill miss", n, 1);
    rd(8'h03, 0, 0, d, n);
    chk(n == 0, "R7 shared kept on older fill", n, 0);
    rd(8'h01, 0, 0, d, n);
    chk(n == 0, "R7 shared kept on older fill", n, 0);
  endtask

  task automatic t_ts_max();
    logic [DW-1:0] d; int n;
    rd(8'h20, 2, 0, d, n);
    rd(8'h30, 3, 0, d, n);
    chk(d == mem[8'h30], "R11 fill data", d, mem[8'h30]);
    rd(8'h01, 0, 0, d, n);
    chk(n == 0, "R11 max kept, no drop on ts equal to max", n, 0);
    rd(8'h03, 0, 0, d, n);
    chk(n == 0, "R11 max kept, other shared line", n, 0);
  endtask

  task automatic t_writes();
    logic [DW-1:0] d; int n; int n0;
    wr(8'h01, 32'h1111_AAAA);
    rd(8'h01, 0, 0, d, n);
    chk(n == 0 && d == 32'h1111_AAAA, "R9 write updates shared copy", d, 32'h1111_AAAA);
    wr(8'h02, 32'h2222_BBBB);
    rd(8'h02, 0, 0, d, n);
    chk(n == 0 && d == 32'h2222_BBBB, "R9 write keeps private state", d, 32'h2222_BBBB);
    wr(8'h40, 32'h4444_CCCC);
    rd(8'h40, 3, 0, d, n);
    chk(n == 1 && d == 32'h4444_CCCC, "R8 write does not allocate", n, 1);
    n0 = nreq;
    wr(8'h50, 32'h5);
    wr(8'h51, 32'h6);
    chk(log_addr[n0 % 64] == 8'h50 && log_addr[(n0+1) % 64] == 8'h51, "R8 program order",
        log_addr[n0 % 64], 8'h50);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_miss_hit_expire();
    t_private_and_inv();
    t_ts_max();
    t_writes();
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule